// File: doc/BRIEF.md
# Two-Level Stacked Interrupt Controller

This block gathers interrupt events from a SCSI core, which reports through two status words, and from a DMA engine, which reports through one. Each word has a visible first-level register that software can read and a hidden second-level register behind it. While any source is pending, new events are parked in the second level. When software clears the current interrupt, the parked events are promoted into view. The request line is active-low and is held inactive for a fixed gap after every read-clear, so the host sees a separate edge for each stacked interrupt.

Per-bit enables decide which events may raise the request line. A fixed per-bit class decides which events are fatal. A fatal event always marks its source pending, even when its enable is off. A non-fatal event whose enable is off only records its status bit. SCSI events are held back while the DMA FIFO holds data and are posted once the FIFO reports empty.

Top module: `irq_stack_ctrl`

## Requirements
- R1: After reset all three status words and the summary read as zero and `irqN` is high.
- R2: While no source is pending, events merge into the first level. This includes several events that arrive in the same cycle on different words.
- R3: While any source is pending, new events are OR-ed into the second-level register of their word and stay out of view. Further events OR into that same register, because there is no third level.
- R4: `rdData` shows the register selected by `rdAddr` in the same cycle. Address 0 is the summary, with bit 0 = DMA pending and bit 1 = SCSI pending, and reading it changes nothing. Addresses 1, 2 and 3 select SCSI word 0, SCSI word 1 and the DMA word. A read of one of them with `rdEn` high clears that first-level word at the clock edge.
- R5: A read-clear after which no first-level pending event remains moves every second-level word up into its first-level word, keeping any bits already there.
- R6: After each read-clear, `irqN` is high for at least HOLD_CYC (3) clocks. It then goes low again if an enabled event is present in the first level.
- R7: An event on a non-fatal bit whose enable is 0 sets its status bit. It does not set a pending bit, does not drive `irqN` low and does not cause stacking.
- R8: A first-level status bit stays set until its word is read-cleared, including when a later enabled event raises an interrupt.
- R9: Once `irqN` is low, it stays low until a read-clear, whatever happens to the enables.
- R10: While `fifoEmpty` is low, SCSI events are held and change no status. They are posted in the cycle `fifoEmpty` is high.
- R11: With the defaults, bits 7..4 of SCSI word 0, bits 3..0 of SCSI word 1 and all DMA bits are fatal. A fatal event with its enable at 0 still sets the pending bit but leaves `irqN` high.
- R12: An event that arrives in the cycle a word is read-clear-promoted goes to that word's second level if that level held data, and into the first level otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| scsiEvt0 | input | WORD_W | One-cycle event bits, SCSI word 0 |
| scsiEvt1 | input | WORD_W | One-cycle event bits, SCSI word 1 |
| dmaEvt | input | WORD_W | One-cycle event bits, DMA word |
| scsiEn0 | input | WORD_W | Request enables, SCSI word 0 |
| scsiEn1 | input | WORD_W | Request enables, SCSI word 1 |
| dmaEn | input | WORD_W | Request enables, DMA word |
| fifoEmpty | input | 1 | High when the DMA FIFO holds no data |
| rdEn | input | 1 | Read strobe, one cycle |
| rdAddr | input | 2 | Register select |
| rdData | output | WORD_W | Selected register contents |
| irqN | output | 1 | Interrupt request, active low |

## Verification
Single events, same-cycle events on several words, and bursts that arrive while a source is pending are each driven and then read back. This shows whether a bit landed in the visible or the hidden level, and whether promotion kept the bits already present. The enable and fatal classes are crossed: masked non-fatal, masked fatal and enabled events are separated by the summary value and the state of the request line. FIFO-busy periods, enable changes under a live request, and events that coincide with a read-clear show whether the gating, the stickiness and the coincidence rule each hold. The request line is sampled on every clock of the post-clear gap.

// File: rtl/sicPkg.sv
package sicPkg;
  localparam int NWORD  = 3;
  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] ADDR_SUM = 2'd0;

  typedef struct packed {
    logic [NWORD-1:0] clr;
    logic             promote;
    logic             stack;
  } sicStrobe_t;
endpackage

// File: rtl/sicGate.sv
module sicGate #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         fifoEmpty,
  input  logic [W-1:0] evt,
  output logic [W-1:0] post
);
  logic [W-1:0] heldQ;

  always_comb post = fifoEmpty ? (heldQ | evt) : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           heldQ <= '0;
    else if (fifoEmpty)  heldQ <= '0;
    else                 heldQ <= heldQ | evt;
  end
endmodule

// File: rtl/sicWord.sv
module sicWord #(
  parameter int           W       = 8,
  parameter logic [W-1:0] FATAL   = '0
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] evt,
  input  logic [W-1:0] en,
  input  logic         clr,
  input  logic         promote,
  input  logic         stack,
  output logic [W-1:0] lvl1,
  output logic         c1,
  output logic         i1
);
  logic [W-1:0] lvl1Q, lvl2Q, nLvl1, nLvl2, base1;
  logic c1Q, i1Q, c2Q, i2Q, nC1, nI1, nC2, nI2;
  logic qualCnt, qualIrq, baseC, baseI, l2Full;

  always_comb begin
    qualCnt = |(evt & (FATAL | en));
    qualIrq = |(evt & en);
    base1   = clr ? '0 : lvl1Q;
    baseC   = clr ? 1'b0 : c1Q;
    baseI   = clr ? 1'b0 : i1Q;
    l2Full  = (lvl2Q != '0);
    nLvl1 = base1; nC1 = baseC; nI1 = baseI;
    nLvl2 = lvl2Q; nC2 = c2Q;   nI2 = i2Q;
    if (promote) begin
      if (l2Full) begin
        nLvl1 = base1 | lvl2Q; nC1 = baseC | c2Q; nI1 = baseI | i2Q;
        nLvl2 = evt;           nC2 = qualCnt;     nI2 = qualIrq;
      end else begin
        nLvl1 = base1 | evt;   nC1 = baseC | qualCnt; nI1 = baseI | qualIrq;
      end
    end else if (stack) begin
      nLvl2 = lvl2Q | evt; nC2 = c2Q | qualCnt; nI2 = i2Q | qualIrq;
    end else begin
      nLvl1 = base1 | evt; nC1 = baseC | qualCnt; nI1 = baseI | qualIrq;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lvl1Q <= '0; lvl2Q <= '0;
      c1Q <= 1'b0; i1Q <= 1'b0; c2Q <= 1'b0; i2Q <= 1'b0;
    end else begin
      lvl1Q <= nLvl1; lvl2Q <= nLvl2;
      c1Q <= nC1; i1Q <= nI1; c2Q <= nC2; i2Q <= nI2;
    end
  end

  assign lvl1 = lvl1Q;
  assign c1   = c1Q;
  assign i1   = i1Q;

  // R3: while stacking without promotion, every arriving bit is kept in level 2
  a_r3_parked: assert property (@(posedge clk) disable iff (!rstN)
    (stack && !promote) |=> ((lvl2Q & $past(evt)) == $past(evt)));

  // R8: visible bits persist until the word is cleared
  a_r8_keep: assert property (@(posedge clk) disable iff (!rstN)
    !clr |=> ((lvl1Q & $past(lvl1Q)) == $past(lvl1Q)));
endmodule

// File: rtl/sicData.sv
module sicData
  import sicPkg::*;
#(
  parameter int           W      = 8,
  parameter logic [W-1:0] FATAL0 = 8'hF0,
  parameter logic [W-1:0] FATAL1 = 8'h0F
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [W-1:0]              scsiEvt0,
  input  logic [W-1:0]              scsiEvt1,
  input  logic [W-1:0]              dmaEvt,
  input  logic [W-1:0]              scsiEn0,
  input  logic [W-1:0]              scsiEn1,
  input  logic [W-1:0]              dmaEn,
  input  logic                      fifoEmpty,
  input  sicStrobe_t                strobe,
  output logic [NWORD-1:0][W-1:0]   lvl1,
  output logic [NWORD-1:0]          c1,
  output logic [NWORD-1:0]          i1
);
  localparam int NSCSI = 2;
  localparam logic [NWORD-1:0][W-1:0] FATAL = {{W{1'b1}}, FATAL1, FATAL0};

  logic [NWORD-1:0][W-1:0] rawEvt, evt, en;

  assign rawEvt = {dmaEvt, scsiEvt1, scsiEvt0};
  assign en     = {dmaEn, scsiEn1, scsiEn0};

  genvar k;
  generate
    for (k = 0; k < NWORD; k++) begin : gWord
      if (k < NSCSI) begin : gGated
        sicGate #(.W(W)) uGate (
          .clk(clk), .rstN(rstN), .fifoEmpty(fifoEmpty),
          .evt(rawEvt[k]), .post(evt[k])
        );
      end else begin : gDirect
        assign evt[k] = rawEvt[k];
      end
      sicWord #(.W(W), .FATAL(FATAL[k])) uWord (
        .clk(clk), .rstN(rstN), .evt(evt[k]), .en(en[k]),
        .clr(strobe.clr[k]), .promote(strobe.promote), .stack(strobe.stack),
        .lvl1(lvl1[k]), .c1(c1[k]), .i1(i1[k])
      );
    end
  endgenerate

  // R10: with the FIFO busy and no clear, SCSI status cannot change
  a_r10_fifo_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!fifoEmpty && strobe.clr == '0 && !strobe.promote) |=>
      (lvl1[0] == $past(lvl1[0]) && lvl1[1] == $past(lvl1[1])));
endmodule

// File: rtl/sicCtrl.sv
module sicCtrl
  import sicPkg::*;
#(
  parameter int W        = 8,
  parameter int HOLD_CYC = 3
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    rdEn,
  input  logic [ADDR_W-1:0]       rdAddr,
  input  logic [NWORD-1:0][W-1:0] lvl1,
  input  logic [NWORD-1:0]        c1,
  input  logic [NWORD-1:0]        i1,
  output sicStrobe_t              strobe,
  output logic [W-1:0]            rdData,
  output logic                    irqN
);
  localparam int HW = $clog2(HOLD_CYC + 1);

  logic          rdClr;
  logic [HW-1:0] holdCnt;
  logic          scsiPend, dmaPend;
  logic [W-1:0]  summary;

  always_comb begin
    rdClr = rdEn && (rdAddr != ADDR_SUM);
    for (int k = 0; k < NWORD; k++)
      strobe.clr[k] = rdClr && (rdAddr == ADDR_W'(k + 1));
    strobe.stack   = |c1;
    strobe.promote = rdClr && ((c1 & ~strobe.clr) == '0);
    scsiPend = c1[0] | c1[1];
    dmaPend  = c1[2];
    summary  = '0;
    summary[0] = dmaPend;
    summary[1] = scsiPend;
    rdData = (rdAddr == ADDR_SUM) ? summary : lvl1[rdAddr - 1'b1];
    irqN   = !((|i1) && (holdCnt == '0));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               holdCnt <= '0;
    else if (rdClr)          holdCnt <= HW'(HOLD_CYC);
    else if (holdCnt != '0)  holdCnt <= holdCnt - 1'b1;
  end

  // R6: request inactive in the two clocks that follow a read-clear
  a_r6_gap1: assert property (@(posedge clk) disable iff (!rstN)
    rdClr |=> irqN);
  a_r6_gap2: assert property (@(posedge clk) disable iff (!rstN)
    $past(rdClr) |=> irqN);

  // R9: an asserted request only leaves through a read-clear
  a_r9_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (!irqN && !rdClr) |=> !irqN);

  // R4: a summary read never alters pending state by itself
  a_r4_sum_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && rdAddr == ADDR_SUM) |-> (strobe.clr == '0 && !strobe.promote));
endmodule

// File: rtl/irq_stack_ctrl.sv
module irq_stack_ctrl
  import sicPkg::*;
#(
  parameter int           WORD_W   = 8,
  parameter int           HOLD_CYC = 3,
  parameter logic [WORD_W-1:0] FATAL0 = 8'hF0,
  parameter logic [WORD_W-1:0] FATAL1 = 8'h0F
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [WORD_W-1:0] scsiEvt0,
  input  logic [WORD_W-1:0] scsiEvt1,
  input  logic [WORD_W-1:0] dmaEvt,
  input  logic [WORD_W-1:0] scsiEn0,
  input  logic [WORD_W-1:0] scsiEn1,
  input  logic [WORD_W-1:0] dmaEn,
  input  logic              fifoEmpty,
  input  logic              rdEn,
  input  logic [1:0]        rdAddr,
  output logic [WORD_W-1:0] rdData,
  output logic              irqN
);
  sicStrobe_t                   strobe;
  logic [NWORD-1:0][WORD_W-1:0] lvl1;
  logic [NWORD-1:0]             c1, i1;

  sicData #(.W(WORD_W), .FATAL0(FATAL0), .FATAL1(FATAL1)) uData (
    .clk(clk), .rstN(rstN),
    .scsiEvt0(scsiEvt0), .scsiEvt1(scsiEvt1), .dmaEvt(dmaEvt),
    .scsiEn0(scsiEn0), .scsiEn1(scsiEn1), .dmaEn(dmaEn),
    .fifoEmpty(fifoEmpty), .strobe(strobe),
    .lvl1(lvl1), .c1(c1), .i1(i1)
  );

  sicCtrl #(.W(WORD_W), .HOLD_CYC(HOLD_CYC)) uCtrl (
    .clk(clk), .rstN(rstN), .rdEn(rdEn), .rdAddr(rdAddr),
    .lvl1(lvl1), .c1(c1), .i1(i1),
    .strobe(strobe), .rdData(rdData), .irqN(irqN)
  );
endmodule

// File: tb/irq_stack_ctrl_test.sv
module irq_stack_ctrl_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] scsiEvt0 = '0, scsiEvt1 = '0, dmaEvt = '0;
  logic [7:0] scsiEn0 = 8'hFF, scsiEn1 = 8'hFF, dmaEn = 8'hFF;
  logic       fifoEmpty = 1'b1;
  logic       rdEn = 1'b0;
  logic [1:0] rdAddr = '0;
  logic [7:0] rdData;
  logic       irqN;

  int nChk = 0;
  int nBad = 0;
  bit done = 0;

  logic [1:0] qAddr[$];
  logic [7:0] qExp[$];
  string      qTag[$];

  always #2.5 clk = ~clk;

  irq_stack_ctrl uut (
    .clk(clk), .rstN(rstN),
    .scsiEvt0(scsiEvt0), .scsiEvt1(scsiEvt1), .dmaEvt(dmaEvt),
    .scsiEn0(scsiEn0), .scsiEn1(scsiEn1), .dmaEn(dmaEn),
    .fifoEmpty(fifoEmpty), .rdEn(rdEn), .rdAddr(rdAddr),
    .rdData(rdData), .irqN(irqN)
  );

  // monitor: compares read data against the scoreboard mid-cycle
  always @(negedge clk) begin
    if (rdEn) begin
      nChk++;
      if (qExp.size() == 0) begin
        nBad++;
        $display("FAIL scoreboard: read with no expectation, actual %h expected none", rdData);
      end else begin
        automatic logic [1:0] a = qAddr.pop_front();
        automatic logic [7:0] e = qExp.pop_front();
        automatic string      t = qTag.pop_front();
        if (rdData !== e) begin
          nBad++;
          $display("FAIL %s: addr %0d actual %h expected %h", t, a, rdData, e);
        end
      end
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic post(input logic [7:0] s0, input logic [7:0] s1, input logic [7:0] d);
    scsiEvt0 = s0; scsiEvt1 = s1; dmaEvt = d;
    tick();
    scsiEvt0 = '0; scsiEvt1 = '0; dmaEvt = '0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [7:0] e, input string t);
    qAddr.push_back(a); qExp.push_back(e); qTag.push_back(t);
    rdEn = 1'b1; rdAddr = a;
    tick();
    rdEn = 1'b0; rdAddr = '0;
  endtask

  task automatic chkIrq(input logic e, input string t);
    nChk++;
    if (irqN !== e) begin
      nBad++;
      $display("FAIL %s: irqN actual %b expected %b", t, irqN, e);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      nChk++; nBad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end

  initial begin
    idle(2);
    rstN = 1'b1;
    tick();
    // R1: reset state
    chkIrq(1'b1, "R1");
    rd(2'd0, 8'h00, "R1");
    rd(2'd1, 8'h00, "R1");
    idle(4);

    // R2 / R4: same-cycle merge on two SCSI words, summary read is harmless
    post(8'h01, 8'h02, 8'h00);
    chkIrq(1'b0, "R2");
    rd(2'd0, 8'h02, "R4");
    rd(2'd0, 8'h02, "R4");
    rd(2'd1, 8'h01, "R2");
    rd(2'd2, 8'h02, "R2");
    rd(2'd0, 8'h00, "R4");
    chkIrq(1'b1, "R4");
    idle(4);

    // R3 / R5 / R6: stacking, hold-off gap and promotion
    post(8'h04, 8'h00, 8'h00);
    post(8'h08, 8'h00, 8'h00);
    post(8'h00, 8'h00, 8'h01);
    post(8'h10, 8'h00, 8'h00);
    rd(2'd1, 8'h04, "R3");
    chkIrq(1'b1, "R6");
    tick(); chkIrq(1'b1, "R6");
    tick(); chkIrq(1'b1, "R6");
    tick(); chkIrq(1'b0, "R6");
    rd(2'd0, 8'h03, "R5");
    rd(2'd3, 8'h01, "R5");
    rd(2'd1, 8'h18, "R5");
    rd(2'd0, 8'h00, "R5");
    idle(4);

    // R7 / R8: masked non-fatal bit 0 of SCSI word 0
    scsiEn0 = 8'hFE;
    post(8'h01, 8'h00, 8'h00);
    chkIrq(1'b1, "R7");
    rd(2'd0, 8'h00, "R7");
    post(8'h02, 8'h00, 8'h00);
    chkIrq(1'b0, "R8");
    rd(2'd1, 8'h03, "R8");
    scsiEn0 = 8'hFF;
    idle(4);

    // R11: masked fatal bit 7 still marks pending and causes stacking
    scsiEn0 = 8'h7F;
    post(8'h80, 8'h00, 8'h00);
    chkIrq(1'b1, "R11");
    rd(2'd0, 8'h02, "R11");
    post(8'h01, 8'h00, 8'h00);
    rd(2'd1, 8'h80, "R11");
    idle(4);
    chkIrq(1'b0, "R11");
    rd(2'd1, 8'h01, "R11");
    scsiEn0 = 8'hFF;
    idle(4);

    // R9: enables dropped under a live request
    post(8'h00, 8'h00, 8'h04);
    chkIrq(1'b0, "R9");
    dmaEn = 8'h00; scsiEn0 = 8'h00;
    idle(3);
    chkIrq(1'b0, "R9");
    dmaEn = 8'hFF; scsiEn0 = 8'hFF;
    rd(2'd3, 8'h04, "R9");
    idle(4);
    chkIrq(1'b1, "R9");

    // R10: SCSI event held behind a busy FIFO
    fifoEmpty = 1'b0;
    post(8'h20, 8'h00, 8'h00);
    tick();
    chkIrq(1'b1, "R10");
    rd(2'd1, 8'h00, "R10");
    idle(4);
    rd(2'd0, 8'h00, "R10");
    fifoEmpty = 1'b1;
    tick();
    chkIrq(1'b0, "R10");
    rd(2'd1, 8'h20, "R10");
    idle(4);

    // R12: event coinciding with a read-clear, level 2 occupied
    post(8'h01, 8'h00, 8'h00);
    post(8'h02, 8'h00, 8'h00);
    scsiEvt0 = 8'h04;
    rd(2'd1, 8'h01, "R12");
    scsiEvt0 = 8'h00;
    idle(4);
    rd(2'd1, 8'h02, "R12");
    idle(4);
    rd(2'd1, 8'h04, "R12");
    idle(4);
    // R12: level 2 empty, coinciding event lands in level 1
    post(8'h01, 8'h00, 8'h00);
    scsiEvt0 = 8'h08;
    rd(2'd1, 8'h01, "R12");
    scsiEvt0 = 8'h00;
    idle(4);
    chkIrq(1'b0, "R12");
    rd(2'd1, 8'h08, "R12");
    idle(4);
    chkIrq(1'b1, "R12");

    if (qExp.size() != 0) begin
      nChk++; nBad++;
      $display("FAIL scoreboard: actual %0d unread expectations expected 0", qExp.size());
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule